// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small set of hardware semaphores that two independent agents, called left and right, use to take turns on shared resources. Each side has its own select line, memory-enable line, write strobe, address and data bus. A side takes a semaphore by writing a word with bit 0 clear, and gives it up or withdraws its claim by writing a word with bit 0 set. On a read it gets back a registered word that shows whether it currently holds that semaphore.

When a side asks for a semaphore the other side already holds, the request is not lost. It is kept pending, and the waiting side becomes the owner on the same clock edge that the holder releases. If both sides claim a free semaphore on the same edge, the left side wins and the right side's claim is kept pending. The block has one clock and a synchronous active-high reset.

Top module: `sem_bank`

## Requirements
- R1: Reset, synchronous and active high, frees every semaphore, clears every pending claim and sets both read registers to all ones.
- R2: Address bits [2:0] pick one of the eight semaphores. The upper address bits have no effect on which semaphore is written or read.
- R3: A write looks only at data bit 0. A 0 in bit 0 is a claim, and a 1 is a release or a withdrawal. Data bits 7:1 are ignored.
- R4: A read puts a word on that side's read bus one cycle after the access edge. The word is all zeros (0x00) when the reader owns the semaphore and all ones (0xFF) when it does not. The read bus holds its value until the next read from that side.
- R5: A claim on a free semaphore makes the claimant the owner on the next edge. The opposite side then reads 0xFF at that index.
- R6: A claim from the non-owner does not take ownership; it is kept as a pending claim. Writes from the non-owner never take ownership away from the owner.
- R7: When the owner releases while the other side has a pending claim, that other side becomes the owner on the same edge.
- R8: When the owner releases with no claim pending, the semaphore becomes free, and both sides read 0xFF.
- R9: If the non-owner writes bit 0 = 1, its pending claim is withdrawn. A later release by the owner then leaves the semaphore free.
- R10: When both sides claim the same free semaphore on the same edge, the left side becomes the owner and the right side's claim becomes pending.
- R11: An access takes place only when select is 1 and memory-enable is 0. Any other combination changes no semaphore and no read register.
- R12: A read returns the state from before the edge on which it happens. A write from the opposite side on that same edge does not change the value captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; an access needs it low |
| l_wr | input | 1 | Left strobe: 1 write, 0 read |
| l_addr | input | 14 | Left address; bits [2:0] pick the semaphore |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left registered read word |
| r_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable; an access needs it low |
| r_wr | input | 1 | Right strobe: 1 write, 0 read |
| r_addr | input | 14 | Right address; bits [2:0] pick the semaphore |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right registered read word |

## Verification
The bench targets the edge where both sides act at once.

- **Same-edge claim.** A design that did not order the two sides would give the semaphore to both or to neither.
- **Release while the other side waits.** A design that dropped the pending claim would leave the semaphore free instead of passing it to the waiting side.
- **Withdrawn claim.** A design that forgot the withdrawal would later grant ownership to a side that has stopped waiting.
- **Read during the other side's write.** A design that read the updated state would return the new owner on the very edge of the change.
- **Ignored fields.** Stray upper address bits, stray data bits and a raised memory-enable line must have no effect. A decoder that used any of them would corrupt the wrong semaphore.

Finally, a long pseudo-random sweep of both sides is checked against a sequential model written from these rules.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 14,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel,
  input  logic          l_mem_en,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_mem_en,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int IW = $clog2(NSEM);

  logic          l_acc, r_acc;
  logic [IW-1:0] l_idx, r_idx;
  logic [NSEM-1:0] req_l, req_r, own_r, own_l;
  logic [NSEM-1:0] req_l_n, req_r_n, own_r_n;

  assign l_acc = l_sel & ~l_mem_en;
  assign r_acc = r_sel & ~r_mem_en;
  assign l_idx = l_addr[IW-1:0];
  assign r_idx = r_addr[IW-1:0];
  assign own_l = req_l & ~own_r;

  for (genvar i = 0; i < NSEM; i++) begin : g_sem
    logic l_hit, r_hit;
    assign l_hit      = l_acc & l_wr & (l_idx == IW'(i));
    assign r_hit      = r_acc & r_wr & (r_idx == IW'(i));
    assign req_l_n[i] = l_hit ? ~l_wdata[0] : req_l[i];
    assign req_r_n[i] = r_hit ? ~r_wdata[0] : req_r[i];
    assign own_r_n[i] = req_r_n[i] & (~req_l_n[i] | own_r[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l   <= '0;
      req_r   <= '0;
      own_r   <= '0;
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      req_l <= req_l_n;
      req_r <= req_r_n;
      own_r <= own_r_n;
      if (l_acc && !l_wr) l_rdata <= {DW{~own_l[l_idx]}};
      if (r_acc && !r_wr) r_rdata <= {DW{~own_r[r_idx]}};
    end
  end
endmodule

module sem_bank_chk #(
  parameter int NSEM = 8,
  parameter int AW   = 14,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            l_sel,
  input logic            l_mem_en,
  input logic            l_wr,
  input logic [AW-1:0]   l_addr,
  input logic [DW-1:0]   l_wdata,
  input logic [DW-1:0]   l_rdata,
  input logic            r_sel,
  input logic            r_mem_en,
  input logic            r_wr,
  input logic [AW-1:0]   r_addr,
  input logic [DW-1:0]   r_wdata,
  input logic [DW-1:0]   r_rdata,
  input logic [NSEM-1:0] req_l,
  input logic [NSEM-1:0] req_r,
  input logic [NSEM-1:0] own_l,
  input logic [NSEM-1:0] own_r
);
  localparam int IW = $clog2(NSEM);
  logic la, ra;
  assign la = l_sel && !l_mem_en;
  assign ra = r_sel && !r_mem_en;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (req_l == '0 && req_r == '0 && l_rdata == '1 && r_rdata == '1));

  // R4
  l_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(la && !l_wr) |=> $stable(l_rdata));

  // R4
  r_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ra && !r_wr) |=> $stable(r_rdata));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!la && !ra) |=> ($stable(req_l) && $stable(req_r) && $stable(own_r)));

  for (genvar i = 0; i < NSEM; i++) begin : g_chk
    logic lt, rt, lc, rc, lr;
    assign lt = la && l_wr && (l_addr[IW-1:0] == IW'(i));
    assign rt = ra && r_wr && (r_addr[IW-1:0] == IW'(i));
    assign lc = lt && !l_wdata[0];
    assign rc = rt && !r_wdata[0];
    assign lr = lt && l_wdata[0];

    // R5
    grant_chk: assert property (@(posedge clk) disable iff (rst)
      (lc && !req_l[i] && !req_r[i] && !rt) |=> (own_l[i] && !own_r[i]));

    // R6
    keep_owner_chk: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && !lt) |=> own_l[i]);

    // R7
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && req_r[i] && lr && !rt) |=> own_r[i]);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
      (own_l[i] && !req_r[i] && lr && !rt) |=> (!req_l[i] && !req_r[i]));

    // R10
    tie_chk: assert property (@(posedge clk) disable iff (rst)
      (lc && rc && !req_l[i] && !req_r[i]) |=> (own_l[i] && req_r[i] && !own_r[i]));
  end
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst),
  .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_addr(l_addr),
  .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_addr(r_addr),
  .r_wdata(r_wdata), .r_rdata(r_rdata),
  .req_l(req_l), .req_r(req_r), .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_tb.sv
module sem_bank_tb_top;
  logic clk = 0, rst = 1;
  logic l_sel = 0, l_mem_en = 0, l_wr = 0, r_sel = 0, r_mem_en = 0, r_wr = 0;
  logic [13:0] l_addr = 0, r_addr = 0;
  logic [7:0]  l_wdata = 0, r_wdata = 0, l_rdata, r_rdata;
  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sem_bank dut_i (.*);

  int mown [8];
  bit mpl [8], mpr [8];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic ls, lm, lw, input logic [13:0] la, input logic [7:0] ld,
                      input logic rs, rm, rw, input logic [13:0] ra, input logic [7:0] rd);
    l_sel = ls; l_mem_en = lm; l_wr = lw; l_addr = la; l_wdata = ld;
    r_sel = rs; r_mem_en = rm; r_wr = rw; r_addr = ra; r_wdata = rd;
    @(posedge clk); @(negedge clk);
    l_sel = 0; r_sel = 0; l_wr = 0; r_wr = 0; l_mem_en = 0; r_mem_en = 0;
  endtask

  task automatic lwr(input logic [13:0] a, input logic [7:0] d);
    step(1, 0, 1, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic rwr(input logic [13:0] a, input logic [7:0] d);
    step(0, 0, 0, 0, 0, 1, 0, 1, a, d);
  endtask
  task automatic rdb(input logic [13:0] a, input string tag, input logic [7:0] el, er);
    step(1, 0, 0, a, 0, 1, 0, 0, a, 0);
    chk({tag, " left"}, l_rdata, el);
    chk({tag, " right"}, r_rdata, er);
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); @(posedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) begin mown[i] = 0; mpl[i] = 0; mpr[i] = 0; end
  endtask

  task automatic mwrite(input int side, input int i, input bit b);
    if (!b) begin
      if (side == 1) mpl[i] = 1; else mpr[i] = 1;
      if (mown[i] == 0) mown[i] = side;
    end else begin
      if (side == 1) mpl[i] = 0; else mpr[i] = 0;
      if (mown[i] == side)
        mown[i] = (side == 1) ? (mpr[i] ? 2 : 0) : (mpl[i] ? 1 : 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 left rdata after reset", l_rdata, 8'hFF);
    chk("R1 right rdata after reset", r_rdata, 8'hFF);
    for (int i = 0; i < 8; i++) rdb(14'(i), "R1 free after reset", 8'hFF, 8'hFF);

    // R5 grant with upper address bits set (R2)
    lwr({11'h2A5, 3'd5}, 8'h00);
    rdb(14'd5, "R5 grant", 8'h00, 8'hFF);
    rdb({11'h7FF, 3'd5}, "R2 upper bits ignored", 8'h00, 8'hFF);
    // R6 pending claim
    rwr(14'd5, 8'h00);
    rdb(14'd5, "R6 denied", 8'h00, 8'hFF);
    rwr(14'd5, 8'h00);
    rdb(14'd5, "R6 owner kept", 8'h00, 8'hFF);
    // R7 handoff
    lwr(14'd5, 8'h01);
    rdb(14'd5, "R7 handoff", 8'hFF, 8'h00);
    // R8 release to free
    rwr(14'd5, 8'h01);
    rdb(14'd5, "R8 free", 8'hFF, 8'hFF);

    // R9 cancel
    rwr(14'd2, 8'h00);
    lwr(14'd2, 8'h00);
    lwr(14'd2, 8'h01);
    rdb(14'd2, "R9 after cancel", 8'hFF, 8'h00);
    rwr(14'd2, 8'h01);
    rdb(14'd2, "R9 free after release", 8'hFF, 8'hFF);

    // R3 only bit 0 counts
    lwr(14'd3, 8'hFE);
    rdb(14'd3, "R3 claim with 0xFE", 8'h00, 8'hFF);
    lwr(14'd3, 8'h01);
    rdb(14'd3, "R3 release with 0x01", 8'hFF, 8'hFF);

    // R10 tie
    step(1, 0, 1, 14'd6, 8'h00, 1, 0, 1, 14'd6, 8'h00);
    rdb(14'd6, "R10 tie left wins", 8'h00, 8'hFF);
    lwr(14'd6, 8'h01);
    rdb(14'd6, "R10 right was pending", 8'hFF, 8'h00);
    rwr(14'd6, 8'h01);

    // R11 gating
    step(1, 1, 1, 14'd1, 8'h00, 0, 0, 1, 14'd1, 8'h00);
    rdb(14'd1, "R11 mem_en blocks write", 8'hFF, 8'hFF);
    lwr(14'd1, 8'h00);
    step(1, 1, 0, 14'd1, 0, 0, 0, 0, 14'd1, 0);
    chk("R11 mem_en blocks read", l_rdata, 8'hFF);
    step(1, 0, 0, 14'd1, 0, 0, 0, 0, 0, 0);
    chk("R11 enabled read", l_rdata, 8'h00);
    lwr(14'd1, 8'h01);

    // R12 read captures pre-edge state
    rwr(14'd4, 8'h00);
    lwr(14'd4, 8'h00);
    step(1, 0, 0, 14'd4, 0, 1, 0, 1, 14'd4, 8'h01);
    chk("R12 old value captured", l_rdata, 8'hFF);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R12 held without read", l_rdata, 8'hFF);
    step(1, 0, 0, 14'd4, 0, 0, 0, 0, 0, 0);
    chk("R12 new value next read", l_rdata, 8'h00);

    // sweep against a model (R4, R6, R7, R10, R11)
    do_reset();
    begin
      logic [31:0] s = 32'h1234_5678;
      logic [7:0] el = 8'hFF, er = 8'hFF;
      for (int n = 0; n < 4000; n++) begin
        logic ls, lm, lw, rs, rm, rw;
        logic [13:0] la, ra;
        logic [7:0] ld, rd;
        int li, ri;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        ls = s[0]; lm = s[1] & s[2]; lw = s[3]; la = s[17:4]; ld = s[25:18];
        rs = s[26]; rm = s[27] & s[28]; rw = s[29]; ra = {s[13:4], s[31:30], s[5]}; rd = s[21:14];
        li = la[2:0]; ri = ra[2:0];
        if (ls && !lm && !lw) el = (mown[li] == 1) ? 8'h00 : 8'hFF;
        if (rs && !rm && !rw) er = (mown[ri] == 2) ? 8'h00 : 8'hFF;
        if (ls && !lm && lw) mwrite(1, li, ld[0]);
        if (rs && !rm && rw) mwrite(2, ri, rd[0]);
        step(ls, lm, lw, la, ld, rs, rm, rw, ra, rd);
        chk("R4 sweep left", l_rdata, el);
        chk("R4 sweep right", r_rdata, er);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule